// File: doc/BRIEF.md
# Transmit Frame Shaper

The shaper sits on the transmit byte stream between a packet source and the MAC line side. It moves one byte per cycle from a start/end-marked input stream to a registered output stream. A frame may only start while the transmit enable is set. Short frames can be extended with zero bytes to the Ethernet minimum. An Ethernet FCS can be computed and appended. The total transfer length of each frame is capped by a programmable limit. When a frame finishes, the block raises a one-cycle pulse that carries the frame's byte count, for use by a statistics block.

The enable is sampled only between frames. A frame that has started is always finished, and later frames wait at the input through back-pressure rather than being discarded. The length limit counts every output byte, so it covers any transmit header the source prepends, plus the data, the pad and the FCS. A synchronous write-one reset pulse returns all state to its power-on values, including state for a frame in flight.

Top module: `txs_frame_shaper`

## Requirements
- R1: After power-on reset the outputs `out_valid` and `done` are low. While idle, `in_ready` equals `cfg_tx_en`.
- R2: A frame starts only when a byte with `in_sop`=1 is presented while `cfg_tx_en`=1. While idle with `cfg_tx_en`=0, `in_ready` is 0, no byte is consumed and nothing is emitted.
- R3: Clearing `cfg_tx_en` in the middle of a frame does not cut that frame. The frame runs to completion with its normal pad and FCS, and only the next frame is held back.
- R4: Each accepted frame byte appears on `out_data` one cycle after acceptance, in order. `out_sop` is set on the first byte of the frame.
- R5: With `cfg_pad_en`=1, a frame shorter than the minimum is extended with 0x00 bytes. The pad target is 60 bytes when `cfg_crc_en`=1 (giving 64 with the FCS) and 64 bytes when `cfg_crc_en`=0. Frames that are already at or above the target are not padded.
- R6: With `cfg_crc_en`=1, four FCS bytes follow the data and pad. The FCS is the complement of the reflected CRC-32 (polynomial 0xEDB88320, initial value 0xFFFFFFFF) taken over data and pad, and it is sent least significant byte first. `out_eop` is set on the last FCS byte.
- R7: With `cfg_crc_en`=0, nothing is appended. `out_eop` is set on the last data or pad byte.
- R8: The data limit is `cfg_max_len` minus 4 when `cfg_crc_en`=1, and `cfg_max_len` otherwise. A frame whose data reaches that limit without `in_eop` is cut at that byte, which carries `out_eop`=1 and `out_err`=1, and no FCS is appended. The rest of the input frame is consumed and discarded. A frame that ends exactly at the limit is not an error.
- R9: `done` pulses for one cycle, together with the final `out_eop` byte. `done_bytes` then holds the frame's total output byte count, including pad and FCS.
- R10: A one-cycle `sw_rst` pulse clears all state: `out_valid` is low in the next cycle, and the next start-marked byte begins a fresh frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sw_rst | input | 1 | Synchronous write-one reset pulse |
| cfg_tx_en | input | 1 | Transmit enable, sampled between frames |
| cfg_pad_en | input | 1 | Pad short frames to the minimum |
| cfg_crc_en | input | 1 | Append the FCS |
| cfg_max_len | input | 14 | Maximum total transfer length in bytes |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_ready | output | 1 | Input byte is consumed this cycle when valid |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | First output byte of a frame |
| out_eop | output | 1 | Last output byte of a frame |
| out_err | output | 1 | Frame was cut at the length limit |
| done | output | 1 | One-cycle frame-complete pulse |
| done_bytes | output | 14 | Total bytes of the completed frame |

## Verification
The bench aims at the edges of the pad rule: a one-byte frame, frames of exactly 60 and 61 bytes with the FCS on, and padding with the FCS off. A shaper that compares against the wrong target would give 68-byte or 60-byte frames. Truncation is driven both one byte past the data limit and exactly at it. An off-by-one there either flags a legal frame or lets a frame run past the limit, and a block that forgets to drain the tail corrupts the next frame. The enable is dropped in the middle of a frame, and the soft reset is pulsed inside a frame. A design that truncated on disable, or that kept its in-frame state through the reset, would lose the FCS or the start marker of the frame that follows.

// File: rtl/txs_pkg.sv
package txs_pkg;

    localparam int FCS_BYTES = 4;
    localparam logic [31:0] CRC_POLY = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT = 32'hFFFFFFFF;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_DATA = 3'd1,
        S_PAD  = 3'd2,
        S_FCS  = 3'd3,
        S_DROP = 3'd4
    } txs_state_e;

    // one byte of reflected CRC-32, bit 0 of the byte first
    function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r >> 1) ^ (((r[0] ^ b[i]) != 1'b0) ? CRC_POLY : 32'h0);
        end
        return r;
    endfunction

endpackage

// File: rtl/txs_crc.sv
module txs_crc
    import txs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);
    logic [31:0] crc_d;

    always_comb begin
        crc_d = crc_q;
        if (en) begin
            crc_d = crc32_byte(clr ? CRC_INIT : crc_q, din);
        end else if (clr) begin
            crc_d = CRC_INIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_INIT;
        else        crc_q <= crc_d;
    end
endmodule

// File: rtl/txs_limits.sv
module txs_limits #(
    parameter int LEN_W     = 14,
    parameter int MIN_FRAME = 64,
    parameter int FCS_BYTES = 4
) (
    input  logic [LEN_W-1:0] max_len,
    input  logic             crc_en,
    output logic [LEN_W-1:0] data_limit,
    output logic [LEN_W-1:0] pad_target
);
    localparam logic [LEN_W-1:0] FCS_L  = LEN_W'(FCS_BYTES);
    localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_FRAME);
    localparam logic [LEN_W-1:0] MIN_NF = LEN_W'(MIN_FRAME - FCS_BYTES);

    assign data_limit = crc_en ? (max_len - FCS_L) : max_len;
    assign pad_target = crc_en ? MIN_NF : MIN_L;
endmodule

// File: rtl/txs_frame_shaper.sv
module txs_frame_shaper
    import txs_pkg::*;
#(
    parameter int LEN_W     = 14,
    parameter int MIN_FRAME = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             cfg_tx_en,
    input  logic             cfg_pad_en,
    input  logic             cfg_crc_en,
    input  logic [LEN_W-1:0] cfg_max_len,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_sop,
    input  logic             in_eop,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_sop,
    output logic             out_eop,
    output logic             out_err,
    output logic             done,
    output logic [LEN_W-1:0] done_bytes
);
    localparam int IDX_W = $clog2(FCS_BYTES);

    typedef struct packed {
        txs_state_e       st;
        logic [LEN_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic             ov;
        logic [7:0]       od;
        logic             osop;
        logic             oeop;
        logic             oerr;
        logic             done;
    } regs_t;

    regs_t q, d;

    logic             crc_clr, crc_en;
    logic [7:0]       crc_din;
    logic [31:0]      crc_q, fcs;
    logic [LEN_W-1:0] data_limit, pad_target, c_next;
    logic             take, rdy;

    txs_limits #(.LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME), .FCS_BYTES(FCS_BYTES)) u_lim (
        .max_len    (cfg_max_len),
        .crc_en     (cfg_crc_en),
        .data_limit (data_limit),
        .pad_target (pad_target)
    );

    txs_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (crc_din),
        .crc_q (crc_q)
    );

    assign fcs = ~crc_q;

    always_comb begin
        d        = q;
        d.ov     = 1'b0;
        d.osop   = 1'b0;
        d.oeop   = 1'b0;
        d.oerr   = 1'b0;
        d.done   = 1'b0;
        crc_clr  = 1'b0;
        crc_en   = 1'b0;
        crc_din  = in_data;
        rdy      = 1'b0;
        take     = 1'b0;
        c_next   = q.cnt + 1'b1;

        unique case (q.st)
            S_IDLE: begin
                rdy = cfg_tx_en;
                if (cfg_tx_en && in_valid && in_sop) begin
                    take    = 1'b1;
                    crc_clr = 1'b1;
                    c_next  = LEN_W'(1);
                    d.osop  = 1'b1;
                end
            end
            S_DATA: begin
                rdy  = 1'b1;
                take = in_valid;
            end
            S_PAD: begin
                d.ov    = 1'b1;
                d.od    = 8'h00;
                d.cnt   = c_next;
                crc_en  = 1'b1;
                crc_din = 8'h00;
                if (c_next >= pad_target) begin
                    if (cfg_crc_en) begin
                        d.st  = S_FCS;
                        d.idx = '0;
                    end else begin
                        d.oeop = 1'b1;
                        d.done = 1'b1;
                        d.st   = S_IDLE;
                    end
                end
            end
            S_FCS: begin
                d.ov  = 1'b1;
                d.od  = fcs[{q.idx, 3'b000} +: 8];
                d.cnt = c_next;
                d.idx = q.idx + 1'b1;
                if (q.idx == IDX_W'(FCS_BYTES - 1)) begin
                    d.oeop = 1'b1;
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end
            S_DROP: begin
                rdy = 1'b1;
                if (in_valid && in_eop) d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase

        if (take) begin
            crc_en = 1'b1;
            d.ov   = 1'b1;
            d.od   = in_data;
            d.cnt  = c_next;
            if (in_eop) begin
                if (cfg_pad_en && (c_next < pad_target)) begin
                    d.st = S_PAD;
                end else if (cfg_crc_en) begin
                    d.st  = S_FCS;
                    d.idx = '0;
                end else begin
                    d.oeop = 1'b1;
                    d.done = 1'b1;
                    d.st   = S_IDLE;
                end
            end else if (c_next >= data_limit) begin
                d.oeop = 1'b1;
                d.oerr = 1'b1;
                d.done = 1'b1;
                d.st   = S_DROP;
            end else begin
                d.st = S_DATA;
            end
        end

        if (sw_rst) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready   = rdy & ~sw_rst;
    assign out_valid  = q.ov;
    assign out_data   = q.od;
    assign out_sop    = q.osop;
    assign out_eop    = q.oeop;
    assign out_err    = q.oerr;
    assign done       = q.done;
    assign done_bytes = q.done ? q.cnt : '0;
endmodule

// File: rtl/txs_chk.sv
module txs_chk #(
    parameter int LEN_W     = 14,
    parameter int MIN_FRAME = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_rst,
    input logic             cfg_tx_en,
    input logic             cfg_pad_en,
    input logic [LEN_W-1:0] cfg_max_len,
    input logic             out_valid,
    input logic             out_sop,
    input logic             out_eop,
    input logic             out_err,
    input logic             done,
    input logic [LEN_W-1:0] done_bytes
);
    // R9
    done_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && out_eop));

    // R9
    eop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_eop) |-> done);

    // R8
    err_on_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_err |-> (out_valid && out_eop));

    // R8
    len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_bytes <= cfg_max_len));

    // R5
    pad_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cfg_pad_en && !out_err) |-> (done_bytes >= LEN_W'(MIN_FRAME)));

    // R2
    sop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sop) |-> $past(cfg_tx_en));

    // R10
    swrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> !out_valid);
endmodule

bind txs_frame_shaper txs_chk #(.LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME)) u_txs_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_rst      (sw_rst),
    .cfg_tx_en   (cfg_tx_en),
    .cfg_pad_en  (cfg_pad_en),
    .cfg_max_len (cfg_max_len),
    .out_valid   (out_valid),
    .out_sop     (out_sop),
    .out_eop     (out_eop),
    .out_err     (out_err),
    .done        (done),
    .done_bytes  (done_bytes)
);

// File: tb/tb_txs_frame_shaper.sv
module tb_txs_frame_shaper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0;
    logic        tx_en = 1'b1, pad_en = 1'b0, crc_en = 1'b1;
    logic [13:0] max_len = 14'd9250;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready, out_valid, out_sop, out_eop, out_err, done;
    logic [7:0]  out_data;
    logic [13:0] done_bytes;

    int    n_chk = 0, n_err = 0;
    string cur_req = "R1";
    logic [10:0] expq[$];
    int          doneq[$];

    always #4 clk = ~clk;

    txs_frame_shaper dut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst),
        .cfg_tx_en(tx_en), .cfg_pad_en(pad_en), .cfg_crc_en(crc_en), .cfg_max_len(max_len),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .out_err(out_err), .done(done), .done_bytes(done_bytes)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        return r;
    endfunction

    // scoreboard monitor: {err, eop, sop, data}
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (expq.size() == 0) begin
                    chk(1'b0, cur_req, "unexpected output byte", 32'(out_data), 32'h0);
                end else begin
                    logic [10:0] e;
                    e = expq.pop_front();
                    chk({out_err, out_eop, out_sop, out_data} == e, cur_req, "output byte",
                        32'({out_err, out_eop, out_sop, out_data}), 32'(e));
                end
            end
            if (done) begin
                if (doneq.size() == 0) begin
                    chk(1'b0, "R9", "unexpected done", 32'(done_bytes), 32'h0);
                end else begin
                    int eb;
                    eb = doneq.pop_front();
                    chk(done_bytes == 14'(eb), "R9", "done byte count", 32'(done_bytes), 32'(eb));
                end
            end
        end
    end

    // driver: builds the expected frame then feeds the input
    task automatic run_frame(input int len, input int dis_at, input bit partial);
        logic [7:0]  b[$];
        logic [31:0] c, f;
        int dl, pt, nout;
        dl = crc_en ? int'(max_len) - 4 : int'(max_len);
        pt = crc_en ? 60 : 64;
        for (int i = 0; i < len; i++) b.push_back(8'(len * 7 + i * 13 + 5));
        if (!partial && len > dl) begin
            for (int i = 0; i < dl; i++)
                expq.push_back({(i == dl - 1), (i == dl - 1), (i == 0), b[i]});
            doneq.push_back(dl);
        end else begin
            nout = (pad_en && len < pt) ? pt : len;
            c = 32'hFFFFFFFF;
            for (int i = 0; i < nout; i++) begin
                logic [7:0] v;
                v = (i < len) ? b[i] : 8'h00;
                c = ref_crc(c, v);
                expq.push_back({1'b0, (!partial && !crc_en && i == nout - 1), (i == 0), v});
            end
            f = ~c;
            if (!partial && crc_en)
                for (int k = 0; k < 4; k++) expq.push_back({1'b0, (k == 3), 1'b0, f[k*8 +: 8]});
            if (!partial) doneq.push_back(nout + (crc_en ? 4 : 0));
        end
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_data  = b[i];
            in_sop   = (i == 0);
            in_eop   = !partial && (i == len - 1);
            if (i == dis_at) tx_en = 1'b0;
            forever begin
                #1;
                if (in_ready) begin
                    @(negedge clk);
                    break;
                end
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        in_sop   = 1'b0;
        in_eop   = 1'b0;
    endtask

    task automatic drain();
        int g;
        g = 0;
        while ((expq.size() != 0 || doneq.size() != 0) && g < 200) begin
            @(negedge clk);
            g++;
        end
        repeat (3) @(negedge clk);
        chk(expq.size() == 0 && doneq.size() == 0, cur_req, "queues drained",
            32'(expq.size()), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, cur_req, "watchdog expired", 32'h0, 32'h1);
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'h0);
        chk(done == 1'b0, "R1", "done after reset", 32'(done), 32'h0);
        chk(in_ready == 1'b1, "R1", "in_ready idle with enable", 32'(in_ready), 32'h1);
        @(negedge clk);

        // R4 and R6: pass-through with FCS
        cur_req = "R6"; run_frame(70, -1, 0); drain();
        cur_req = "R4"; run_frame(1, -1, 0); drain();

        // R5 padding with FCS, including boundaries
        pad_en = 1'b1;
        cur_req = "R5"; run_frame(20, -1, 0); drain();
        cur_req = "R5"; run_frame(1, -1, 0); drain();
        cur_req = "R5"; run_frame(59, -1, 0); drain();
        cur_req = "R5"; run_frame(60, -1, 0); drain();
        cur_req = "R5"; run_frame(61, -1, 0); drain();

        // R7 no FCS, with and without padding
        crc_en = 1'b0;
        cur_req = "R7"; run_frame(10, -1, 0); drain();
        pad_en = 1'b0;
        cur_req = "R7"; run_frame(30, -1, 0); drain();

        // R8 truncation at the limit, exact-limit frames, tail drained
        crc_en = 1'b1; max_len = 14'd80;
        cur_req = "R8"; run_frame(100, -1, 0); run_frame(40, -1, 0); drain();
        cur_req = "R8"; run_frame(76, -1, 0); drain();
        crc_en = 1'b0;
        cur_req = "R8"; run_frame(81, -1, 0); run_frame(80, -1, 0); drain();
        crc_en = 1'b1; max_len = 14'd9250;

        // R2 gating: a start byte waits while the enable is low
        cur_req = "R2";
        tx_en = 1'b0;
        in_valid = 1'b1; in_sop = 1'b1; in_data = 8'hA5;
        repeat (10) begin
            #1;
            chk(in_ready == 1'b0, "R2", "in_ready with enable low", 32'(in_ready), 32'h0);
            @(negedge clk);
        end
        in_valid = 1'b0; in_sop = 1'b0;
        tx_en = 1'b1;
        run_frame(25, -1, 0); drain();

        // R3 enable cleared mid-frame: frame completes, next waits
        cur_req = "R3";
        pad_en = 1'b1;
        run_frame(40, 10, 0); drain();
        #1;
        chk(in_ready == 1'b0, "R3", "held after disable", 32'(in_ready), 32'h0);
        @(negedge clk);
        tx_en = 1'b1;
        run_frame(45, -1, 0); drain();

        // R10 soft reset inside a frame, then a fresh frame
        cur_req = "R10";
        pad_en = 1'b0; crc_en = 1'b0;
        run_frame(5, -1, 1);
        sw_rst = 1'b1;
        @(negedge clk);
        sw_rst = 1'b0;
        #1;
        chk(out_valid == 1'b0, "R10", "out_valid after soft reset", 32'(out_valid), 32'h0);
        chk(in_ready == 1'b1, "R10", "idle after soft reset", 32'(in_ready), 32'h1);
        @(negedge clk);
        crc_en = 1'b1;
        run_frame(12, -1, 0); drain();

        summary();
        $finish;
    end
endmodule